// File: doc/BRIEF.md
# Receive Parallel Bus Output Formatter

This block sits between a deserializer that has already found word boundaries and a protocol controller. Each incoming 10-bit code group comes with a valid flag and a flag that marks a comma word. The block places the code group on a parallel data bus and generates the receive byte clocks that go with it. It also drives a sync line that marks the comma word.

All logic runs on one internal clock at twice the word rate. The formatter accepts one word per slot of two internal clocks. Two static select inputs choose one of three bus formats:
- full-rate: one byte clock and a 10-bit bus.
- half-rate: two complementary byte clocks, each running at half the word rate, with the protocol controller sampling alternately on each clock.
- nibble double-data-rate: two 5-bit halves per word, one on each edge of a full-rate byte clock.

The format is taken from the select inputs only while synchronous reset is asserted.

Top module: `rx_bus_formatter`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it, `rbc0`, `rbc1`, `rd` and `sync` are all zero. Slots start at the first internal edge after reset is released and then alternate every two internal clocks.
- R2: The selects `{modeSel, rateSel}` are sampled only during reset. 00 selects half-rate, 01 selects full-rate, and 1x selects nibble mode with `rateSel` ignored. Changing the selects outside reset has no effect on the outputs.
- R3: Full-rate: `rbc1` stays low. `rbc0` is low for the first internal clock of each slot and high for the second. `rd` takes the new word on the edge where `rbc0` falls, one internal clock before it rises.
- R4: Half-rate: each byte clock is high for two internal clocks and low for two. `rbc1` rises in the second internal clock of even slots, starting with the first slot after reset, so byte 0 is sampled on `rbc1`. `rbc0` rises in odd slots. From the first rise onward the two clocks are complementary. `rd` carries the full word and changes one internal clock before the clock it belongs to rises.
- R5: Nibble mode: `rbc0` is high in the first internal clock of each slot and low in the second, and `rbc1` stays low. Bits 4:0 of the word appear on `rd[4:0]` starting at the rising edge of `rbc0`. Bits 9:5 appear on `rd[4:0]` starting at the falling edge. `rd[9:5]` is always zero.
- R6: `sync` equals the comma flag of the word on the bus and is held for the whole slot, including both halves in nibble mode.
- R7: A slot with `inValid` low leaves `rd` at its previous value, drives `sync` low for that slot, and does not disturb the byte clocks.
- R8: Inputs are sampled only on the internal edge that begins a slot. Values present on the second edge of a slot have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the word rate |
| rst | input | 1 | Synchronous reset, active high; latches the format selects |
| modeSel | input | 1 | Format select: 1 selects nibble double-data-rate |
| rateSel | input | 1 | With modeSel low: 1 full-rate, 0 half-rate |
| inValid | input | 1 | A word is present for this slot |
| inWord | input | 10 | Aligned received code group |
| inComma | input | 1 | Code group is the comma word |
| rbc0 | output | 1 | Receive byte clock 0 |
| rbc1 | output | 1 | Receive byte clock 1 (half-rate only) |
| rd | output | 10 | Receive data bus |
| sync | output | 1 | Comma word marker |

## Verification
The assertions assume that the select inputs matter only while reset is high. They also assume that `inValid`, `inWord` and `inComma` are stable over each slot's first internal edge. Under these assumptions the byte-clock patterns, the zero upper lines in nibble mode and a held `sync` follow from the latched format alone. The stimulus changes every input only on falling clock edges and sweeps all four select codes. It also changes the selects in the middle of a run, to show they are ignored there. Data inputs are scrambled on each second edge, so any sampling outside the slot boundary would show on the bus.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef enum logic [1:0] {
    MODE_HALF   = 2'd0,
    MODE_FULL   = 2'd1,
    MODE_NIBBLE = 2'd2
  } busMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // first edge of a slot: take the input word
    logic upperHalf;  // second edge of a slot in nibble mode
    logic packHalves; // nibble format in force
  } strobes_t;

endpackage

// File: rtl/rxfmt_ctrl.sv
module rxfmt_ctrl
  import rxfmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     modeSel,
  input  logic     rateSel,
  output busMode_t mode,
  output logic     phase,
  output logic     rbc0,
  output logic     rbc1,
  output strobes_t stb
);

  logic     slotOdd;
  busMode_t modeDec;

  always_comb begin
    if (modeSel)      modeDec = MODE_NIBBLE;
    else if (rateSel) modeDec = MODE_FULL;
    else              modeDec = MODE_HALF;
  end

  // format is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= modeDec;
      phase   <= 1'b0;
      slotOdd <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) slotOdd <= ~slotOdd;
    end
  end

  // byte clock generation, registered from the internal clock
  always_ff @(posedge clk) begin
    if (rst) begin
      rbc0 <= 1'b0;
      rbc1 <= 1'b0;
    end else begin
      case (mode)
        MODE_FULL: begin
          rbc0 <= phase;
          rbc1 <= 1'b0;
        end
        MODE_NIBBLE: begin
          rbc0 <= ~phase;
          rbc1 <= 1'b0;
        end
        default: begin
          if (phase) begin
            rbc1 <= ~slotOdd;
            rbc0 <= slotOdd;
          end
        end
      endcase
    end
  end

  always_comb begin
    stb.capture    = ~phase;
    stb.packHalves = (mode == MODE_NIBBLE);
    stb.upperHalf  = phase & (mode == MODE_NIBBLE);
  end

endmodule

// File: rtl/rxfmt_dpath.sv
module rxfmt_dpath
  import rxfmt_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inComma,
  output logic [WORD_W-1:0] rd,
  output logic              sync
);

  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] upperHeld;
  logic              slotLive;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd        <= '0;
      sync      <= 1'b0;
      upperHeld <= '0;
      slotLive  <= 1'b0;
    end else if (stb.capture) begin
      slotLive <= inValid;
      if (inValid) begin
        upperHeld <= inWord[WORD_W-1:HALF_W];
        sync      <= inComma;
        if (stb.packHalves) rd <= {{(WORD_W-HALF_W){1'b0}}, inWord[HALF_W-1:0]};
        else                rd <= inWord;
      end else begin
        sync <= 1'b0;
      end
    end else if (stb.upperHalf && slotLive) begin
      rd <= {{(WORD_W-HALF_W){1'b0}}, upperHeld};
    end
  end

endmodule

// File: rtl/rx_bus_formatter.sv
module rx_bus_formatter
  import rxfmt_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic              rateSel,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inComma,
  output logic              rbc0,
  output logic              rbc1,
  output logic [WORD_W-1:0] rd,
  output logic              sync
);

  busMode_t mode;
  logic     phase;
  strobes_t stb;

  rxfmt_ctrl i_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .rateSel(rateSel),
    .mode(mode), .phase(phase), .rbc0(rbc0), .rbc1(rbc1), .stb(stb)
  );

  rxfmt_dpath #(.WORD_W(WORD_W)) i_dpath (
    .clk(clk), .rst(rst), .stb(stb), .inValid(inValid), .inWord(inWord),
    .inComma(inComma), .rd(rd), .sync(sync)
  );

endmodule

// File: rtl/rx_bus_formatter_chk.sv
module rx_bus_formatter_chk
  import rxfmt_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              rbc0,
  input logic              rbc1,
  input logic [WORD_W-1:0] rd,
  input logic              sync,
  input logic              inValid,
  input busMode_t          mode,
  input logic              phase
);

  localparam int HALF_W = WORD_W / 2;

  AST_RBC1_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_HALF) |-> !rbc1); // R3

  AST_FULL_RISE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FULL && phase) |=> rbc0); // R3

  AST_HALF_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALF) |-> !(rbc0 && rbc1)); // R4

  AST_NIBBLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_NIBBLE) |-> (rd[WORD_W-1:HALF_W] == '0)); // R5

  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (rst)
    phase |=> $stable(sync)); // R6

  AST_MISSING_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!phase && !inValid) |=> !sync); // R7

endmodule

bind rx_bus_formatter rx_bus_formatter_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .rbc0(rbc0), .rbc1(rbc1), .rd(rd), .sync(sync),
  .inValid(inValid), .mode(mode), .phase(phase)
);

// File: tb/test_rx_bus_formatter.sv
`timescale 1ns/1ps
module test_rx_bus_formatter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic       rateSel = 1'b0;
  logic       inValid = 1'b0;
  logic [9:0] inWord = '0;
  logic       inComma = 1'b0;
  logic       rbc0, rbc1, sync;
  logic [9:0] rd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rx_bus_formatter i_rx_bus_formatter (
    .clk(clk), .rst(rst), .modeSel(modeSel), .rateSel(rateSel),
    .inValid(inValid), .inWord(inWord), .inComma(inComma),
    .rbc0(rbc0), .rbc1(rbc1), .rd(rd), .sync(sync)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // run one format from reset; flip changes the selects mid-run (R2)
  task automatic runMode(input logic ms, input logic rs, input int nSlots, input bit flip);
    int fmt;            // 0 half, 1 full, 2 nibble
    int lastRd;
    int expRd, expSync, expR0, expR1;
    int word;
    bit valid, comma;
    fmt = ms ? 2 : (rs ? 1 : 0);
    @(negedge clk);
    rst = 1'b1; modeSel = ms; rateSel = rs; inValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "rbc0 in reset", rbc0, 0);
    chk("R1", "rbc1 in reset", rbc1, 0);
    chk("R1", "rd in reset", rd, 0);
    chk("R1", "sync in reset", sync, 0);
    rst = 1'b0;
    lastRd = 0;
    expR0 = 0; expR1 = 0;
    for (int s = 0; s < nSlots; s++) begin
      word  = (s * 173 + ms * 61 + rs * 29 + 7) % 1024;
      valid = (s % 7) != 3;
      comma = (s % 5) == 1;
      inWord = word[9:0]; inValid = valid; inComma = comma;
      if (flip && s == 4) begin modeSel = ~ms; rateSel = ~rs; end
      @(posedge clk); @(negedge clk);
      // first half of slot
      expRd = valid ? ((fmt == 2) ? (word % 32) : word) : lastRd;
      expSync = (valid && comma) ? 1 : 0;
      if (fmt == 1) begin expR0 = 0; expR1 = 0; end
      if (fmt == 2) begin expR0 = 1; expR1 = 0; end
      chk(fmt == 2 ? "R5" : (fmt == 1 ? "R3" : "R4"), "rd first half", rd, expRd);
      chk(valid ? "R6" : "R7", "sync first half", sync, expSync);
      chk(fmt == 0 ? "R4" : "R2", "rbc0 first half", rbc0, expR0);
      chk(fmt == 0 ? "R4" : "R2", "rbc1 first half", rbc1, expR1);
      if (s == 0) chk("R1", "no clock before first slot edge", rbc0 | rbc1, fmt == 2 ? 1 : 0);
      // scramble inputs: second edge must not sample (R8)
      inWord = ~word[9:0]; inValid = ~valid; inComma = ~comma;
      @(posedge clk); @(negedge clk);
      if (fmt == 2 && valid) expRd = word / 32;
      if (fmt == 1) begin expR0 = 1; expR1 = 0; end
      if (fmt == 2) begin expR0 = 0; expR1 = 0; end
      if (fmt == 0) begin expR1 = (s % 2 == 0) ? 1 : 0; expR0 = 1 - expR1; end
      chk(fmt == 2 ? "R5" : "R8", "rd second half", rd, expRd);
      chk("R6", "sync second half", sync, expSync);
      chk(fmt == 1 ? "R3" : (fmt == 2 ? "R5" : "R4"), "rbc0 second half", rbc0, expR0);
      chk(fmt == 0 ? "R4" : "R2", "rbc1 second half", rbc1, expR1);
      lastRd = expRd;
    end
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    runMode(1'b0, 1'b0, 40, 1'b0);  // half-rate
    runMode(1'b0, 1'b1, 40, 1'b0);  // full-rate
    runMode(1'b1, 1'b0, 40, 1'b0);  // nibble
    runMode(1'b1, 1'b1, 40, 1'b0);  // nibble, rateSel ignored (R2)
    runMode(1'b0, 1'b1, 30, 1'b1);  // full-rate, selects change mid-run (R2)
    runMode(1'b0, 1'b0, 30, 1'b1);  // half-rate, selects change mid-run (R2)
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule